// File: doc/BRIEF.md
# User-Mode Address Relocation and Window Guard

This block sits between a processor's memory-request port and the memory system. Each request carries a 32-bit byte address, a valid strobe and the current privilege bit. In privileged (system) mode the address is already physical and passes through unchanged. In user mode the address is first compared against a limit register and then offset by a relocation register. The block holds both registers, and only system mode can load them.

The resulting physical address is steered to one of two fixed windows. Addresses from 0xF000_0000 upward belong to the I/O window. Addresses below that belong to the memory window, which is further cut off at the size of the installed RAM. A request that breaks any rule is aborted. Such a request raises a fault pulse that carries the program-error parameter code 2, and no downstream strobe is issued for it. The translation path is combinational, so a request and its result sit in the same cycle. The downstream ready signal is passed back to the requester.

Top module: `addr_reloc_guard`

## Requirements
- R1: After reset the relocation and limit registers are both zero, so every user-mode request faults, because no address is below a limit of zero.
- R2: With mode_user low, a cycle with cfg_we high loads cfg_wdata into the relocation register when cfg_sel is 0, or into the limit register when cfg_sel is 1. A request in the following cycle sees the new value.
- R3: With mode_user high, cfg_we has no effect on either register. This is seen in later translations, which keep using the old values.
- R4: In system mode a non-faulting request drives phys_addr equal to req_addr, whatever the two registers hold.
- R5: In user mode a request whose req_addr is greater than or equal to the limit register faults.
- R6: In user mode a request that does not fault drives phys_addr equal to req_addr plus the relocation register.
- R7: In user mode, if req_addr plus the relocation register carries out of 32 bits, the request faults.
- R8: A non-faulting request whose physical address is at least 0xF000_0000 raises io_valid and leaves mem_valid low.
- R9: In either mode, a physical address below 0xF000_0000 and above the installed-memory limit 0x00FF_FFFF faults. Below or at that limit it raises mem_valid.
- R10: A fault raises fault_valid with fault_code equal to 2, and neither mem_valid nor io_valid rises for that request.
- R11: req_ready equals dn_ready for a non-faulting request, and it is 1 for a faulting request, which is consumed at once.
- R12: At most one of mem_valid, io_valid and fault_valid is high in any cycle, and all three are low when req_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_user | input | 1 | 1 = user mode, 0 = system mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects relocation register, 1 selects limit register |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_addr | input | 32 | Logical byte address |
| req_ready | output | 1 | Request accepted this cycle |
| dn_ready | input | 1 | Downstream ready |
| phys_addr | output | 32 | Physical address |
| mem_valid | output | 1 | Memory-window strobe |
| io_valid | output | 1 | I/O-window strobe |
| fault_valid | output | 1 | Request aborted by a bounds fault |
| fault_code | output | 2 | Program-error parameter, 2 on a fault |

## Verification
The hardest case to reach is a user request that passes the limit test but whose relocated sum either carries out of 32 bits or falls into the gap between installed RAM and the I/O window. Each of these needs a particular pairing of register values and address. The stimulus therefore sweeps a grid of relocation values placed near the gap and the top of the address space, combines them with several limits, including the all-ones limit, and drives addresses at each window edge in both modes. The expected outcome of every point is computed from a 33-bit sum. Separate stimulus attempts register writes while in user mode and then shows through later translations that the old values survive.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
   localparam int unsigned FAULT_W = 2;
   localparam logic [FAULT_W-1:0] FAULT_BOUNDS = 2'd2;

   typedef enum logic [1:0] {
      SPACE_HOLE = 2'd0,
      SPACE_MEM  = 2'd1,
      SPACE_IO   = 2'd2
   } space_e;
endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          user_mode,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] base_q,
   output logic [AW-1:0] limit_q
);
   logic wr_ok;
   assign wr_ok = wr_en & ~user_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (wr_ok) begin
         if (wr_sel) limit_q <= wr_data;
         else        base_q  <= wr_data;
      end
   end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
   parameter int unsigned AW          = 32,
   parameter bit          CARRY_FAULT = 1'b1
) (
   input  logic          user_mode,
   input  logic [AW-1:0] log_addr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] limit,
   output logic [AW-1:0] phys,
   output logic          viol
);
   localparam int unsigned SW = AW + 1;

   logic [SW-1:0] sum;
   logic          over_limit;
   logic          carry_viol;

   assign sum        = {1'b0, base} + {1'b0, log_addr};
   assign over_limit = (log_addr >= limit);

   generate
      if (CARRY_FAULT) begin : g_carry_chk
         assign carry_viol = sum[SW-1];
      end else begin : g_carry_wrap
         assign carry_viol = 1'b0;
      end
   endgenerate

   always_comb begin
      if (user_mode) begin
         phys = sum[AW-1:0];
         viol = over_limit | carry_viol;
      end else begin
         phys = log_addr;
         viol = 1'b0;
      end
   end
endmodule

// File: rtl/reloc_space_decode.sv
module reloc_space_decode
   import reloc_pkg::*;
#(
   parameter int unsigned   AW        = 32,
   parameter logic [AW-1:0] IO_BASE   = 32'hF000_0000,
   parameter logic [AW-1:0] MEM_LIMIT = 32'h00FF_FFFF
) (
   input  logic [AW-1:0] phys,
   output space_e        space
);
   localparam logic [AW-1:0] WIN_TOP = IO_BASE - 1'b1;
   localparam bit            FULL_RAM = (MEM_LIMIT == WIN_TOP);

   logic in_io;
   logic ram_ok;

   assign in_io = (phys >= IO_BASE);

   generate
      if (FULL_RAM) begin : g_full_ram
         assign ram_ok = 1'b1;
      end else begin : g_part_ram
         assign ram_ok = (phys <= MEM_LIMIT);
      end
   endgenerate

   always_comb begin
      if (in_io)       space = SPACE_IO;
      else if (ram_ok) space = SPACE_MEM;
      else             space = SPACE_HOLE;
   end
endmodule

// File: rtl/addr_reloc_guard.sv
module addr_reloc_guard
   import reloc_pkg::*;
#(
   parameter int unsigned   AW          = 32,
   parameter logic [AW-1:0] IO_BASE     = 32'hF000_0000,
   parameter logic [AW-1:0] MEM_LIMIT   = 32'h00FF_FFFF,
   parameter bit            CARRY_FAULT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_user,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [AW-1:0]      cfg_wdata,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_addr,
   output logic               req_ready,
   input  logic               dn_ready,
   output logic [AW-1:0]      phys_addr,
   output logic               mem_valid,
   output logic               io_valid,
   output logic               fault_valid,
   output logic [FAULT_W-1:0] fault_code
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("addr_reloc_guard: AW must be at least 8");
      end
      if (MEM_LIMIT >= IO_BASE) begin : g_bad_win
         $error("addr_reloc_guard: MEM_LIMIT must lie below IO_BASE");
      end
   endgenerate

   logic [AW-1:0] cfg_base_q;
   logic [AW-1:0] cfg_bound_q;
   logic          xl_viol;
   space_e        space;
   logic          bad;

   reloc_cfg_regs #(.AW(AW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .user_mode (mode_user),
      .wr_en     (cfg_we),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .base_q    (cfg_base_q),
      .limit_q   (cfg_bound_q)
   );

   reloc_xlate #(.AW(AW), .CARRY_FAULT(CARRY_FAULT)) u_xlate (
      .user_mode (mode_user),
      .log_addr  (req_addr),
      .base      (cfg_base_q),
      .limit     (cfg_bound_q),
      .phys      (phys_addr),
      .viol      (xl_viol)
   );

   reloc_space_decode #(.AW(AW), .IO_BASE(IO_BASE), .MEM_LIMIT(MEM_LIMIT)) u_dec (
      .phys  (phys_addr),
      .space (space)
   );

   assign bad         = xl_viol | (space == SPACE_HOLE);
   assign fault_valid = req_valid & bad;
   assign fault_code  = fault_valid ? FAULT_BOUNDS : '0;
   assign mem_valid   = req_valid & ~bad & (space == SPACE_MEM);
   assign io_valid    = req_valid & ~bad & (space == SPACE_IO);
   assign req_ready   = bad ? 1'b1 : dn_ready;
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
   parameter int unsigned   AW      = 32,
   parameter logic [AW-1:0] IO_BASE = 32'hF000_0000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_user,
   input logic          cfg_we,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic [AW-1:0] cfg_base_q,
   input logic [AW-1:0] cfg_bound_q,
   input logic [AW-1:0] phys_addr,
   input logic          mem_valid,
   input logic          io_valid,
   input logic          fault_valid,
   input logic [1:0]    fault_code
);
   // R3
   user_cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_user && cfg_we) |=> ($stable(cfg_base_q) && $stable(cfg_bound_q)));

   // R4
   sys_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_user && (mem_valid || io_valid)) |-> (phys_addr == req_addr));

   // R5
   user_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_user && req_valid && (req_addr >= cfg_bound_q)) |-> fault_valid);

   // R8
   io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |-> (phys_addr >= IO_BASE));

   // R10
   fault_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_code == 2'd2 && !mem_valid && !io_valid));

   // R12
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_valid, io_valid, fault_valid}));

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(mem_valid || io_valid || fault_valid));
endmodule

bind addr_reloc_guard reloc_guard_chk #(.AW(AW), .IO_BASE(IO_BASE)) u_chk (.*);

// File: tb/addr_reloc_guard_tb.sv
module addr_reloc_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_user = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready;
   logic        dn_ready = 1'b0;
   logic [31:0] phys_addr;
   logic        mem_valid;
   logic        io_valid;
   logic        fault_valid;
   logic [1:0]  fault_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   addr_reloc_guard u_dut (
      .clk(clk), .rst_n(rst_n), .mode_user(mode_user), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_ready(req_ready), .dn_ready(dn_ready),
      .phys_addr(phys_addr), .mem_valid(mem_valid), .io_valid(io_valid),
      .fault_valid(fault_valid), .fault_code(fault_code)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h (addr=%h user=%0d)", req, act, exp, req_addr, mode_user);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [31:0] val, input logic as_user);
      @(negedge clk);
      req_valid = 1'b0;
      mode_user = as_user;
      cfg_we = 1'b1;
      cfg_sel = sel;
      cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [31:0] base_at(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_1000;
         2: return 32'h00FF_0000;
         3: return 32'hEFFF_F000;
         4: return 32'hF000_0000;
         default: return 32'hFFFF_FF00;
      endcase
   endfunction

   function automatic logic [31:0] bound_at(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0100;
         2: return 32'h0001_0000;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] addr_at(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h0000_00FF;
         3: return 32'h0000_0100;
         4: return 32'h0000_FFFF;
         5: return 32'h0001_0000;
         6: return 32'h00FF_FFFF;
         7: return 32'h0100_0000;
         8: return 32'hEFFF_FFFF;
         9: return 32'hF000_0000;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic apply_and_check(input logic usr, input logic [31:0] base,
                                  input logic [31:0] bound, input logic [31:0] a,
                                  input logic rdy);
      logic [32:0] sum;
      logic [31:0] ph;
      logic        f;
      logic        m;
      logic        io;
      @(negedge clk);
      mode_user = usr;
      req_valid = 1'b1;
      req_addr = a;
      dn_ready = rdy;
      f = 1'b0;
      if (usr) begin
         sum = {1'b0, base} + {1'b0, a};
         ph = sum[31:0];
         if (a >= bound) f = 1'b1;   // R5
         if (sum[32]) f = 1'b1;      // R7
      end else begin
         ph = a;                     // R4
      end
      io = 1'b0;
      m = 1'b0;
      if (!f) begin
         if (ph >= 32'hF000_0000) io = 1'b1;        // R8
         else if (ph > 32'h00FF_FFFF) f = 1'b1;      // R9
         else m = 1'b1;
      end
      #1;
      check("R10 fault_valid", {31'd0, fault_valid}, {31'd0, f});
      check("R9 mem_valid", {31'd0, mem_valid}, {31'd0, m});
      check("R8 io_valid", {31'd0, io_valid}, {31'd0, io});
      check("R11 req_ready", {31'd0, req_ready}, {31'd0, f ? 1'b1 : rdy});
      if (f) check("R10 fault_code", {30'd0, fault_code}, 32'd2);
      else   check(usr ? "R6 phys_addr" : "R4 phys_addr", phys_addr, ph);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: after reset the limit is zero, so a user request faults
      apply_and_check(1'b1, 32'h0, 32'h0, 32'h0000_0000, 1'b1);
      apply_and_check(1'b1, 32'h0, 32'h0, 32'h0000_0040, 1'b0);
      // R1: system mode with zero relocation passes through
      apply_and_check(1'b0, 32'h0, 32'h0, 32'h0000_0040, 1'b1);

      // R12: idle request gives no outcome
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check("R12 idle outcomes", {29'd0, mem_valid, io_valid, fault_valid}, 32'd0);

      // R2, R4..R11 sweep
      for (int ib = 0; ib < 6; ib++) begin
         for (int il = 0; il < 4; il++) begin
            write_reg(1'b0, base_at(ib), 1'b0);
            write_reg(1'b1, bound_at(il), 1'b0);
            for (int ia = 0; ia < 11; ia++) begin
               for (int md = 0; md < 2; md++) begin
                  apply_and_check(md[0], base_at(ib), bound_at(il), addr_at(ia), ia[0]);
               end
            end
         end
      end

      // R3: writes attempted in user mode are ignored
      write_reg(1'b0, 32'h0000_1000, 1'b0);
      write_reg(1'b1, 32'h0000_0100, 1'b0);
      write_reg(1'b0, 32'h0000_5000, 1'b1);
      write_reg(1'b1, 32'h0000_FFFF, 1'b1);
      apply_and_check(1'b1, 32'h0000_1000, 32'h0000_0100, 32'h0000_0010, 1'b1);
      apply_and_check(1'b1, 32'h0000_1000, 32'h0000_0100, 32'h0000_0200, 1'b1);
      @(negedge clk);
      mode_user = 1'b1;
      req_valid = 1'b1;
      req_addr = 32'h0000_0020;
      #1;
      check("R3 relocation kept", phys_addr, 32'h0000_1020);

      // R7: carry out of the sum with a limit that allows the address
      write_reg(1'b0, 32'hFFFF_FFF0, 1'b0);
      write_reg(1'b1, 32'hFFFF_FFFF, 1'b0);
      apply_and_check(1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_0010, 1'b1);
      apply_and_check(1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_000F, 1'b1);

      @(negedge clk);
      req_valid = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule